// File: doc/BRIEF.md
# CPU Clock-Unit Register Model

This block is a cycle-based behavioural model of the register file of a CPU clock management unit. Software programs a PLL lock time, the PLL divider fields (P, M, S), the CPU clock source select and two CPU divider words through a plain 32-bit register port. The port has an address, a write strobe, write data and read data. Status words report how far each change has got. A PLL reconfiguration drops the lock flag until the programmed lock time has run out. A divider write shows busy bits for a fixed settle time. A source switch shows a transitional mux state before it reports the new source.

The model is meant for firmware bring-up and for system benches that drive frequency-change sequences. The typical sequence is to move the CPU onto the alternate clock, reprogram the PLL, poll for lock and move back. Each of these polls finishes after a known number of cycles. Read data is combinational from the address, and a write takes effect on the clock edge where the strobe is high.

Top module: `cpu_clk_regs`

## Requirements
- R1: After reset every register and status word reads zero, except the mux status word at 0x400, which reads 0x00010000.
- R2: The lock-time register at 0x000 stores write-data bits 19:0 and reads them back, with bits 31:20 as zero.
- R3: The PLL configuration register at 0x100 stores S in bits 2:0, P in bits 13:8 and M in bits 25:16. All other bits read zero except bit 29, the locked flag, which software cannot write.
- R4: A write to 0x100 clears the locked flag on that edge. With a lock time L, the flag stays clear on the next L clock edges and reads 1 after edge L+1. A write to 0x100 while a lock is pending restarts the count.
- R5: The divider registers at 0x500 (CPU0) and 0x504 (CPU1) each store and return the full 32-bit word.
- R6: A write to 0x500 makes 0x600 read 0x11111111 (busy bits 0,4,...,28) for 4 cycles after the write edge, and 0 after that. A write to 0x504 makes 0x604 read 0x00000011 (bits 0 and 4) for the same 4 cycles. The two words are independent of each other, and a repeated write restarts the 4 cycles.
- R7: The source register at 0x200 stores write-data bit 16 only: 0 selects the main PLL and 1 selects the alternate clock. All other bits read zero.
- R8: After a write to 0x200, the 3-bit field at bits 18:16 of 0x400 reads 0 for 2 cycles. It then reads 1 if the main PLL is selected or 2 if the alternate clock is selected.
- R9: Unmapped offsets read zero and ignore writes. Writes to the status words 0x400, 0x600 and 0x604 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The assertions take for granted that the write strobe and write data are stable across the active clock edge. They also assume that the lock time programmed before a PLL configuration write is the value the lock count should use, so a lock-time write has no effect on a count that is already running. The bench drives the address, strobe and data only on falling edges. It holds the strobe for exactly one rising edge per write. It reads only after the inputs have settled, so every status word is observed in a known cycle relative to the write that caused it.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 12;

  localparam logic [OFF_W-1:0] OFF_LOCK    = 12'h000;
  localparam logic [OFF_W-1:0] OFF_PLL     = 12'h100;
  localparam logic [OFF_W-1:0] OFF_SRC     = 12'h200;
  localparam logic [OFF_W-1:0] OFF_MUXSTAT = 12'h400;
  localparam logic [OFF_W-1:0] OFF_DIV0    = 12'h500;
  localparam logic [OFF_W-1:0] OFF_DIV1    = 12'h504;
  localparam logic [OFF_W-1:0] OFF_DSTAT0  = 12'h600;
  localparam logic [OFF_W-1:0] OFF_DSTAT1  = 12'h604;

  // PLL field positions
  localparam int unsigned S_LSB = 0,  S_W = 3;
  localparam int unsigned P_LSB = 8,  P_W = 6;
  localparam int unsigned M_LSB = 16, M_W = 10;
  localparam int unsigned LOCKED_BIT = 29;
  localparam int unsigned SRC_BIT = 16;
  localparam int unsigned MUXSTAT_LSB = 16;

  typedef enum logic [2:0] {
    MUX_MOVING = 3'd0,
    MUX_MAIN   = 3'd1,
    MUX_ALT    = 3'd2
  } mux_stat_e;

  // busy bits sit every fourth bit from 0
  function automatic logic [DATA_W-1:0] busy_word(input int unsigned nbits);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < 8; k++)
      if (k < int'(nbits)) w[4*k] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/clk_lock_timer.sv
module clk_lock_timer #(
  parameter int unsigned LOCK_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LOCK_W-1:0] lock_time_i,
  output logic              locked_o
);
  logic [LOCK_W-1:0] cnt_q;
  logic              pend_q;
  logic              locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (cfg_we_i) begin
      cnt_q    <= lock_time_i;
      pend_q   <= 1'b1;
      locked_q <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        pend_q   <= 1'b0;
        locked_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign locked_o = locked_q;

  p_lock_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !locked_o);
  p_lock_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q != '0) |=> !locked_o);
  p_lock_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q == '0 && !cfg_we_i) |=> locked_o);
endmodule

// File: rtl/clk_div_timer.sv
module clk_div_timer #(
  parameter int unsigned SETTLE = 4,
  localparam int unsigned CNT_W = $clog2(SETTLE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (we_i)          cnt_q <= CNT_W'(SETTLE);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> busy_o);
  p_busy_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SETTLE));
endmodule

// File: rtl/clk_mux_tracker.sv
module clk_mux_tracker #(
  parameter int unsigned SETTLE = 2,
  localparam int unsigned CNT_W = $clog2(SETTLE + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       sel_i,
  output logic       sel_o,
  output logic [2:0] stat_o
);
  import cpu_clk_pkg::*;

  logic             sel_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (we_i) begin
      sel_q <= sel_i;
      cnt_q <= CNT_W'(SETTLE);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sel_o  = sel_q;
  assign stat_o = (cnt_q != '0) ? MUX_MOVING : (sel_q ? MUX_ALT : MUX_MAIN);

  p_mux_moving_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> stat_o == 3'd0);
  p_mux_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_o));
endmodule

// File: rtl/cpu_clk_regs.sv
module cpu_clk_regs
  import cpu_clk_pkg::*;
#(
  parameter int unsigned LOCK_W     = 20,
  parameter int unsigned DIV_SETTLE = 4,
  parameter int unsigned MUX_SETTLE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned N_DIV = 2;

  logic [LOCK_W-1:0] lock_q;
  logic [S_W-1:0]    s_q;
  logic [P_W-1:0]    p_q;
  logic [M_W-1:0]    m_q;
  logic              pll_we;
  logic              locked;
  logic              src_we;
  logic              src_sel;
  logic [2:0]        mux_stat;

  logic [DATA_W-1:0] div_q    [N_DIV];
  logic [DATA_W-1:0] dstat    [N_DIV];
  logic              div_busy [N_DIV];

  assign pll_we = we_i && (addr_i == OFF_PLL);
  assign src_we = we_i && (addr_i == OFF_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      s_q    <= '0;
      p_q    <= '0;
      m_q    <= '0;
    end else begin
      if (we_i && addr_i == OFF_LOCK) lock_q <= wdata_i[LOCK_W-1:0];
      if (pll_we) begin
        s_q <= wdata_i[S_LSB +: S_W];
        p_q <= wdata_i[P_LSB +: P_W];
        m_q <= wdata_i[M_LSB +: M_W];
      end
    end
  end

  clk_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (pll_we),
    .lock_time_i (lock_q),
    .locked_o    (locked)
  );

  clk_mux_tracker #(.SETTLE(MUX_SETTLE)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (src_we),
    .sel_i  (wdata_i[SRC_BIT]),
    .sel_o  (src_sel),
    .stat_o (mux_stat)
  );

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    localparam logic [OFF_W-1:0] OFF = OFF_DIV0 + OFF_W'(4 * g);
    localparam int unsigned NBUSY = (g == 0) ? 8 : 2;
    logic wr;
    assign wr = we_i && (addr_i == OFF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  div_q[g] <= '0;
      else if (wr)  div_q[g] <= wdata_i;
    end

    clk_div_timer #(.SETTLE(DIV_SETTLE)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr),
      .busy_o (div_busy[g])
    );

    assign dstat[g] = div_busy[g] ? busy_word(NBUSY) : '0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_LOCK: rdata_o[LOCK_W-1:0] = lock_q;
      OFF_PLL: begin
        rdata_o[S_LSB +: S_W]  = s_q;
        rdata_o[P_LSB +: P_W]  = p_q;
        rdata_o[M_LSB +: M_W]  = m_q;
        rdata_o[LOCKED_BIT]    = locked;
      end
      OFF_SRC:     rdata_o[SRC_BIT] = src_sel;
      OFF_MUXSTAT: rdata_o[MUXSTAT_LSB +: 3] = mux_stat;
      OFF_DIV0:    rdata_o = div_q[0];
      OFF_DIV1:    rdata_o = div_q[1];
      OFF_DSTAT0:  rdata_o = dstat[0];
      OFF_DSTAT1:  rdata_o = dstat[1];
      default:     rdata_o = '0;
    endcase
  end

  p_src_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_we |=> $stable(src_sel));
  p_stat_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_MUXSTAT && !$past(src_we)) |=> $stable(mux_stat));
  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 12'h300) |-> rdata_o == '0);
endmodule

// File: tb/cpu_clk_regs_test.sv
module cpu_clk_regs_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_clk_regs uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  // {addr, we, wdata, expected read}; one entry per cycle
  localparam logic [76:0] VEC [NVEC] = '{
    {12'h000, 1'b0, 32'h0, 32'h00000000},  // 0  R1
    {12'h100, 1'b0, 32'h0, 32'h00000000},  // 1  R1
    {12'h400, 1'b0, 32'h0, 32'h00010000},  // 2  R1
    {12'h600, 1'b0, 32'h0, 32'h00000000},  // 3  R1
    {12'h000, 1'b1, 32'hFFF00003, 32'h0},  // 4  lock=3
    {12'h000, 1'b0, 32'h0, 32'h00000003},  // 5  R2
    {12'h100, 1'b1, 32'h20C80401, 32'h0},  // 6  config write
    {12'h100, 1'b0, 32'h0, 32'h00C80401},  // 7  R3 R4
    {12'h100, 1'b0, 32'h0, 32'h00C80401},  // 8  R4
    {12'h100, 1'b0, 32'h0, 32'h00C80401},  // 9  R4
    {12'h100, 1'b0, 32'h0, 32'h00C80401},  // 10 R4
    {12'h100, 1'b0, 32'h0, 32'h20C80401},  // 11 R4 locked
    {12'h500, 1'b1, 32'h01117710, 32'h0},  // 12
    {12'h600, 1'b0, 32'h0, 32'h11111111},  // 13 R6
    {12'h604, 1'b0, 32'h0, 32'h00000000},  // 14 R6
    {12'h600, 1'b0, 32'h0, 32'h11111111},  // 15 R6
    {12'h600, 1'b0, 32'h0, 32'h11111111},  // 16 R6
    {12'h600, 1'b0, 32'h0, 32'h00000000},  // 17 R6
    {12'h500, 1'b0, 32'h0, 32'h01117710},  // 18 R5
    {12'h504, 1'b1, 32'h00000020, 32'h0},  // 19
    {12'h604, 1'b0, 32'h0, 32'h00000011},  // 20 R6
    {12'h600, 1'b0, 32'h0, 32'h00000000},  // 21 R6
    {12'h504, 1'b0, 32'h0, 32'h00000020},  // 22 R5
    {12'h604, 1'b0, 32'h0, 32'h00000011},  // 23 R6
    {12'h604, 1'b0, 32'h0, 32'h00000000},  // 24 R6
    {12'h200, 1'b1, 32'hFFFFFFFF, 32'h0},  // 25
    {12'h400, 1'b0, 32'h0, 32'h00000000},  // 26 R8
    {12'h400, 1'b0, 32'h0, 32'h00000000},  // 27 R8
    {12'h400, 1'b0, 32'h0, 32'h00020000},  // 28 R8
    {12'h200, 1'b0, 32'h0, 32'h00010000},  // 29 R7
    {12'h200, 1'b1, 32'h00000000, 32'h0},  // 30
    {12'h400, 1'b0, 32'h0, 32'h00000000},  // 31 R8
    {12'h400, 1'b0, 32'h0, 32'h00000000},  // 32 R8
    {12'h400, 1'b0, 32'h0, 32'h00010000},  // 33 R8
    {12'h300, 1'b1, 32'hDEADBEEF, 32'h0},  // 34
    {12'h300, 1'b0, 32'h0, 32'h00000000},  // 35 R9
    {12'h600, 1'b1, 32'hFFFFFFFF, 32'h0},  // 36
    {12'h600, 1'b0, 32'h0, 32'h00000000},  // 37 R9
    {12'h400, 1'b1, 32'h00000000, 32'h0},  // 38
    {12'h400, 1'b0, 32'h0, 32'h00010000}   // 39 R9
  };

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, a, rdata, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][64]) wr(VEC[i][76:65], VEC[i][63:32]);
      else            chk(VEC[i][76:65], VEC[i][31:0], $sformatf("vec%0d", i));
    end

    // R4: zero lock time locks one edge after the write
    wr(12'h000, 32'h0);
    wr(12'h100, 32'h00000001);
    chk(12'h100, 32'h00000001, "R4 lock0 pending");
    chk(12'h100, 32'h20000001, "R4 lock0 locked");

    // R4: rewrite while pending restarts the count (L=2)
    wr(12'h000, 32'h2);
    wr(12'h100, 32'h00000001);
    chk(12'h100, 32'h00000001, "R4 first pending");
    wr(12'h100, 32'h00000002);
    chk(12'h100, 32'h00000002, "R4 restart 1");
    chk(12'h100, 32'h00000002, "R4 restart 2");
    chk(12'h100, 32'h00000002, "R4 restart 3");
    chk(12'h100, 32'h20000002, "R4 restart locked");

    // R6: second divider write restarts the busy window
    wr(12'h500, 32'hA5A5A5A5);
    chk(12'h600, 32'h11111111, "R6 busy a");
    chk(12'h600, 32'h11111111, "R6 busy b");
    wr(12'h500, 32'h5A5A5A5A);
    for (int k = 0; k < 4; k++) chk(12'h600, 32'h11111111, "R6 restart busy");
    chk(12'h600, 32'h00000000, "R6 restart idle");
    chk(12'h500, 32'h5A5A5A5A, "R5 last write");

    // R1: asynchronous reset mid-run
    wr(12'h200, 32'h00010000);
    @(negedge clk) rst_n = 1'b0;
    #1;
    checks++;
    if (rdata !== 32'h0 && addr == 12'h200) begin
      errors++;
      $display("FAIL R1 src after reset got=%h exp=%h", rdata, 32'h0);
    end
    addr = 12'h400; #1;
    checks++;
    if (rdata !== 32'h00010000) begin
      errors++;
      $display("FAIL R1 muxstat after reset got=%h exp=%h", rdata, 32'h00010000);
    end
    addr = 12'h500; #1;
    checks++;
    if (rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 div0 after reset got=%h exp=%h", rdata, 32'h0);
    end
    @(negedge clk) rst_n = 1'b1;
    chk(12'h100, 32'h00000000, "R1 pll after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule